// File: doc/BRIEF.md
# Multiplexed Bus Write Sequencer

This block turns write requests into bus cycles on a shared address/data system bus that carries one byte-lane parity bit per lane. A request is either a single write of 1 to 8 bytes or a 32-byte block write. Each request produces an address phase and then one or more data phases. Between the address phase and the first data phase the block inserts a programmable number of idle cycles, from 0 to 7. This gives slow memories, such as synchronous DRAM behind a simple controller, time to open a row before the write data arrives.

The bus runs either 64 bits wide or 32 bits wide, selected per request. In the narrow mode, block writes take twice as many data beats. A single write wider than one word is cut into two complete transactions. An external write-ready input decides whether a new transaction may begin. An optional pipelined mode allows exactly one more write to start after write-ready has dropped. Consecutive single writes on the wide bus can follow each other at one write every two cycles.

Top module: `sysbus_wr_seq`

## Requirements
- R1: The cycle after a request is accepted (req_valid and req_ready high at a clock edge), the bus shows the address phase: bus_valid=1, bus_addr_phase=1, bus_ad = address zero-extended, bus_cmd[3] = block flag, bus_cmd[2:0] = byte count minus one (0 for a block).
- R2: Exactly gap_cfg idle cycles (value latched at acceptance, 0 to 7) separate each address phase from its first data phase; with 0 the data follows the address at once.
- R3: A block write in 64-bit mode (mode32=0) has 4 data beats; beat k carries req_data[64k+63:64k], and bus_last marks the fourth.
- R4: A block write in 32-bit mode has 8 data beats; beat k carries req_data[32k+31:32k] on bus_ad[31:0] with bus_ad[63:32]=0, and bus_last marks the eighth.
- R5: A single write has one data beat: req_data[63:0] in 64-bit mode, or req_data[31:0] in 32-bit mode when req_size is 4 or less.
- R6: In 32-bit mode a single write of 5 to 8 bytes becomes two transactions. The first has bus_cmd[2:0]=3 and carries data[31:0]. The second uses address+4, has bus_cmd[2:0]=size-5 and carries data[63:32]. Each has its own address phase, gap and bus_last.
- R7: bus_chk[i] is the even parity of byte lane i of bus_ad (the XOR of its 8 bits); in 32-bit mode bus_chk[7:4]=0.
- R8: A new request can be accepted while the final data beat is on the bus, so single 64-bit writes with gap 0 occupy the bus with no idle cycle, one write every 2 cycles.
- R9: req_ready is high only when the bus is idle or shows the final beat of a request, and only when wr_ready is high or a pipelined credit is held.
- R10: With pipe_en=1, a cycle with wr_ready high grants one credit; exactly one request may then start while wr_ready is low, and none after it until wr_ready returns. With pipe_en=0 no request starts while wr_ready is low.
- R11: While no phase is driven (idle or gap cycles), bus_valid, bus_addr_phase, bus_last, bus_cmd, bus_ad and bus_chk are all 0.
- R12: During and right after reset the bus is idle with all outputs at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode32 | input | 1 | 1 selects 32-bit bus mode for the request being accepted |
| gap_cfg | input | 3 | Idle cycles between address and data, latched at acceptance |
| pipe_en | input | 1 | Enables one extra write after wr_ready drops |
| wr_ready | input | 1 | External permission to start a write |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted at this edge when req_valid is high |
| req_block | input | 1 | 1 = 32-byte block write, 0 = single write |
| req_size | input | 4 | Byte count 1 to 8 for single writes |
| req_addr | input | 32 | Write address |
| req_data | input | 256 | Write payload, byte 0 in bits 7:0 |
| bus_ad | output | 64 | Multiplexed address/data bus |
| bus_chk | output | 8 | Per-lane even parity bits |
| bus_cmd | output | 4 | Address-phase command: block flag and byte count minus one |
| bus_valid | output | 1 | A phase is driven this cycle |
| bus_addr_phase | output | 1 | The driven phase is an address |
| bus_last | output | 1 | Final data beat of a transaction |

## Verification
The address phase is due on the cycle after the accepting edge. It is followed by exactly the latched number of gap cycles and then one beat per cycle, so each accepted request maps onto a fixed run of future bus cycles. The bench appends that run to a queue of expected bus cycles at the accepting edge. It pops one entry per clock and compares it with the outputs 1 ns after each falling edge, when the registered state of the preceding rising edge has settled. req_ready is due combinationally in the same cycle. It is predicted from the queue depth, the wr_ready value the bench drives in that cycle, and a modelled pipelined credit.

// File: rtl/sysbus_wr_pkg.sv
package sysbus_wr_pkg;

  // Sequencer phase; the encoding is what the bus currently shows.
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_GAP  = 2'd2,
    ST_DATA = 2'd3
  } seq_state_e;

endpackage

// File: rtl/sysbus_wr_issue_gate.sv
// Start permission: wr_ready, or one stored pipelined credit.
module sysbus_wr_issue_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_ready,
  input  logic pipe_en,
  input  logic slot_free,
  input  logic accept,
  output logic grant
);

  logic spare_q;
  logic spare_d;

  always_comb begin
    spare_d = spare_q;
    if (wr_ready) begin
      spare_d = pipe_en;
    end else if (accept) begin
      spare_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      spare_q <= 1'b0;
    end else begin
      spare_q <= spare_d;
    end
  end

  assign grant = slot_free && (wr_ready || spare_q);

endmodule

// File: rtl/sysbus_wr_ctrl.sv
// Phase sequencing, gap counting, beat counting and request latching.
module sysbus_wr_ctrl
  import sysbus_wr_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int BUS_W     = 64,
  parameter int BLK_BYTES = 32,
  parameter int GAP_W     = 3,
  localparam int LANES    = BUS_W / 8,
  localparam int SIZE_W   = $clog2(LANES) + 1,
  localparam int HALF_W   = BUS_W / 2,
  localparam int BLK_BITS = BLK_BYTES * 8,
  localparam int BEATS_W  = BLK_BITS / BUS_W,
  localparam int BEATS_N  = BLK_BITS / HALF_W,
  localparam int BEAT_W   = $clog2(BEATS_N)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                accept,
  input  logic                req_block,
  input  logic [SIZE_W-1:0]   req_size,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [BLK_BITS-1:0] req_data,
  input  logic                mode32,
  input  logic [GAP_W-1:0]    gap_cfg,
  output seq_state_e          state,
  output logic [BEAT_W-1:0]   beat,
  output logic                second,
  output logic                lat_block,
  output logic                lat_m32,
  output logic [SIZE_W-1:0]   lat_size,
  output logic [ADDR_W-1:0]   lat_addr,
  output logic [BLK_BITS-1:0] lat_data,
  output logic                last_beat,
  output logic                slot_free
);

  seq_state_e          st_q, st_d;
  logic [BEAT_W-1:0]   beat_q, beat_d;
  logic [GAP_W-1:0]    gap_q, gap_d;
  logic                second_q, second_d;
  logic                load;

  logic                blk_q, m32_q;
  logic [SIZE_W-1:0]   size_q;
  logic [ADDR_W-1:0]   addr_q;
  logic [BLK_BITS-1:0] data_q;
  logic [GAP_W-1:0]    gcfg_q;

  logic [BEAT_W-1:0]   last_idx;
  logic                split_pend;

  always_comb begin
    if (!blk_q) begin
      last_idx = '0;
    end else if (m32_q) begin
      last_idx = BEAT_W'(BEATS_N - 1);
    end else begin
      last_idx = BEAT_W'(BEATS_W - 1);
    end
  end

  assign split_pend = !blk_q && m32_q && (size_q > SIZE_W'(LANES / 2)) && !second_q;
  assign last_beat  = (st_q == ST_DATA) && (beat_q == last_idx);
  assign slot_free  = (st_q == ST_IDLE) || (last_beat && !split_pend);

  // Next-state process
  always_comb begin
    st_d     = st_q;
    beat_d   = beat_q;
    gap_d    = gap_q;
    second_d = second_q;
    load     = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (accept) begin
          st_d = ST_ADDR;
          load = 1'b1;
        end
      end
      ST_ADDR: begin
        beat_d = '0;
        if (gcfg_q == '0) begin
          st_d = ST_DATA;
        end else begin
          st_d  = ST_GAP;
          gap_d = gcfg_q - GAP_W'(1);
        end
      end
      ST_GAP: begin
        if (gap_q == '0) begin
          st_d = ST_DATA;
        end else begin
          gap_d = gap_q - GAP_W'(1);
        end
      end
      ST_DATA: begin
        if (!last_beat) begin
          beat_d = beat_q + BEAT_W'(1);
        end else if (split_pend) begin
          st_d     = ST_ADDR;
          second_d = 1'b1;
        end else if (accept) begin
          st_d = ST_ADDR;
          load = 1'b1;
        end else begin
          st_d = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
    if (load) begin
      second_d = 1'b0;
    end
  end

  // Control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      beat_q   <= '0;
      gap_q    <= '0;
      second_q <= 1'b0;
    end else begin
      st_q     <= st_d;
      beat_q   <= beat_d;
      gap_q    <= gap_d;
      second_q <= second_d;
    end
  end

  // Request capture, enabled by load
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_q  <= 1'b0;
      m32_q  <= 1'b0;
      size_q <= '0;
      addr_q <= '0;
      data_q <= '0;
      gcfg_q <= '0;
    end else if (load) begin
      blk_q  <= req_block;
      m32_q  <= mode32;
      size_q <= req_size;
      addr_q <= req_addr;
      data_q <= req_data;
      gcfg_q <= gap_cfg;
    end
  end

  assign state     = st_q;
  assign beat      = beat_q;
  assign second    = second_q;
  assign lat_block = blk_q;
  assign lat_m32   = m32_q;
  assign lat_size  = size_q;
  assign lat_addr  = addr_q;
  assign lat_data  = data_q;

endmodule

// File: rtl/sysbus_wr_beat_mux.sv
// Selects what the bus carries in the current phase.
module sysbus_wr_beat_mux
  import sysbus_wr_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int BUS_W     = 64,
  parameter int BLK_BYTES = 32,
  localparam int LANES    = BUS_W / 8,
  localparam int SIZE_W   = $clog2(LANES) + 1,
  localparam int HALF_W   = BUS_W / 2,
  localparam int BLK_BITS = BLK_BYTES * 8,
  localparam int BEAT_W   = $clog2(BLK_BITS / HALF_W)
) (
  input  seq_state_e          state,
  input  logic [BEAT_W-1:0]   beat,
  input  logic                second,
  input  logic                lat_block,
  input  logic                lat_m32,
  input  logic [SIZE_W-1:0]   lat_size,
  input  logic [ADDR_W-1:0]   lat_addr,
  input  logic [BLK_BITS-1:0] lat_data,
  output logic [BUS_W-1:0]    ad,
  output logic [SIZE_W-1:0]   cmd,
  output logic [LANES-1:0]    lane_en,
  output logic                valid,
  output logic                addr_phase
);

  logic [SIZE_W-2:0] bytes_m1;
  logic [BEAT_W-1:0] half_idx;
  logic              oversize;

  assign oversize = lat_m32 && (lat_size > SIZE_W'(LANES / 2));
  assign half_idx = lat_block ? beat : BEAT_W'(second);

  always_comb begin
    if (lat_block) begin
      bytes_m1 = '0;
    end else if (oversize && !second) begin
      bytes_m1 = (SIZE_W-1)'(LANES / 2 - 1);
    end else if (oversize) begin
      bytes_m1 = (SIZE_W-1)'(lat_size - SIZE_W'(LANES / 2 + 1));
    end else begin
      bytes_m1 = (SIZE_W-1)'(lat_size - SIZE_W'(1));
    end
  end

  always_comb begin
    ad      = '0;
    cmd     = '0;
    lane_en = lat_m32 ? {{(LANES/2){1'b0}}, {(LANES/2){1'b1}}} : {LANES{1'b1}};
    unique case (state)
      ST_ADDR: begin
        ad  = BUS_W'(lat_addr + (second ? ADDR_W'(HALF_W / 8) : ADDR_W'(0)));
        cmd = {lat_block, bytes_m1};
      end
      ST_DATA: begin
        if (lat_m32) begin
          ad = BUS_W'(lat_data[half_idx*HALF_W +: HALF_W]);
        end else begin
          ad = lat_data[beat*BUS_W +: BUS_W];
        end
      end
      default: ;
    endcase
  end

  assign valid      = (state == ST_ADDR) || (state == ST_DATA);
  assign addr_phase = (state == ST_ADDR);

endmodule

// File: rtl/sysbus_wr_lane_par.sv
// Even parity per enabled byte lane.
module sysbus_wr_lane_par #(
  parameter int BUS_W  = 64,
  localparam int LANES = BUS_W / 8
) (
  input  logic [BUS_W-1:0] ad,
  input  logic [LANES-1:0] lane_en,
  output logic [LANES-1:0] chk
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign chk[g] = lane_en[g] & (^ad[8*g +: 8]);
  end

endmodule

// File: rtl/sysbus_wr_seq.sv
module sysbus_wr_seq
  import sysbus_wr_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int BUS_W     = 64,
  parameter int BLK_BYTES = 32,
  parameter int GAP_W     = 3,
  localparam int LANES    = BUS_W / 8,
  localparam int SIZE_W   = $clog2(LANES) + 1,
  localparam int BLK_BITS = BLK_BYTES * 8,
  localparam int BEAT_W   = $clog2(BLK_BITS / (BUS_W / 2))
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mode32,
  input  logic [GAP_W-1:0]    gap_cfg,
  input  logic                pipe_en,
  input  logic                wr_ready,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_block,
  input  logic [SIZE_W-1:0]   req_size,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [BLK_BITS-1:0] req_data,
  output logic [BUS_W-1:0]    bus_ad,
  output logic [LANES-1:0]    bus_chk,
  output logic [SIZE_W-1:0]   bus_cmd,
  output logic                bus_valid,
  output logic                bus_addr_phase,
  output logic                bus_last
);

  // Reset: asserted asynchronously, released on the clock
  logic rst_meta, rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_core_n <= rst_meta;
    end
  end

  seq_state_e          state;
  logic [BEAT_W-1:0]   beat;
  logic                second, lat_block, lat_m32;
  logic [SIZE_W-1:0]   lat_size;
  logic [ADDR_W-1:0]   lat_addr;
  logic [BLK_BITS-1:0] lat_data;
  logic                last_beat, slot_free, grant, accept;
  logic [LANES-1:0]    lane_en;

  assign accept    = req_valid && grant;
  assign req_ready = grant;

  sysbus_wr_issue_gate u_gate (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .wr_ready  (wr_ready),
    .pipe_en   (pipe_en),
    .slot_free (slot_free),
    .accept    (accept),
    .grant     (grant)
  );

  sysbus_wr_ctrl #(
    .ADDR_W(ADDR_W), .BUS_W(BUS_W), .BLK_BYTES(BLK_BYTES), .GAP_W(GAP_W)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .accept    (accept),
    .req_block (req_block),
    .req_size  (req_size),
    .req_addr  (req_addr),
    .req_data  (req_data),
    .mode32    (mode32),
    .gap_cfg   (gap_cfg),
    .state     (state),
    .beat      (beat),
    .second    (second),
    .lat_block (lat_block),
    .lat_m32   (lat_m32),
    .lat_size  (lat_size),
    .lat_addr  (lat_addr),
    .lat_data  (lat_data),
    .last_beat (last_beat),
    .slot_free (slot_free)
  );

  sysbus_wr_beat_mux #(
    .ADDR_W(ADDR_W), .BUS_W(BUS_W), .BLK_BYTES(BLK_BYTES)
  ) u_mux (
    .state      (state),
    .beat       (beat),
    .second     (second),
    .lat_block  (lat_block),
    .lat_m32    (lat_m32),
    .lat_size   (lat_size),
    .lat_addr   (lat_addr),
    .lat_data   (lat_data),
    .ad         (bus_ad),
    .cmd        (bus_cmd),
    .lane_en    (lane_en),
    .valid      (bus_valid),
    .addr_phase (bus_addr_phase)
  );

  sysbus_wr_lane_par #(.BUS_W(BUS_W)) u_par (
    .ad      (bus_ad),
    .lane_en (lane_en),
    .chk     (bus_chk)
  );

  assign bus_last = last_beat;

endmodule

// File: rtl/sysbus_wr_seq_checker.sv
module sysbus_wr_seq_checker #(
  parameter int BUS_W  = 64,
  parameter int CMD_W  = 4,
  localparam int LANES = BUS_W / 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_ready,
  input logic             req_valid,
  input logic             req_ready,
  input logic [BUS_W-1:0] bus_ad,
  input logic [LANES-1:0] bus_chk,
  input logic [CMD_W-1:0] bus_cmd,
  input logic             bus_valid,
  input logic             bus_addr_phase,
  input logic             bus_last
);

  // R1: an accepted request shows its address next cycle
  a_r1_addr_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (bus_valid && bus_addr_phase));

  // R11: nothing driven outside a phase
  a_r11_quiet_when_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_valid |-> (bus_ad == '0 && bus_chk == '0 && bus_cmd == '0 && !bus_last));

  // R7: every lane even, so the whole bus plus check bits has even weight
  a_r7_even_weight: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> ($countones({bus_chk, bus_ad}) % 2 == 0));

  // R3: last marks a data beat only
  a_r3_last_is_data: assert property (@(posedge clk) disable iff (!rst_n)
    bus_last |-> (bus_valid && !bus_addr_phase));

  // R9: no start while a transaction is mid-flight
  a_r9_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_last) |-> !req_ready);

  // R10: only one start on a credit while write-ready stays low
  a_r10_single_credit: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !wr_ready) |=> (wr_ready || !req_ready));

endmodule

bind sysbus_wr_seq sysbus_wr_seq_checker #(.BUS_W(BUS_W), .CMD_W(SIZE_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .wr_ready       (wr_ready),
  .req_valid      (req_valid),
  .req_ready      (req_ready),
  .bus_ad         (bus_ad),
  .bus_chk        (bus_chk),
  .bus_cmd        (bus_cmd),
  .bus_valid      (bus_valid),
  .bus_addr_phase (bus_addr_phase),
  .bus_last       (bus_last)
);

// File: tb/sysbus_wr_seq_bench.sv
module sysbus_wr_seq_bench;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic         rst_n;
  logic         mode32, pipe_en, wr_ready, req_valid, req_ready, req_block;
  logic [2:0]   gap_cfg;
  logic [3:0]   req_size, bus_cmd;
  logic [31:0]  req_addr;
  logic [255:0] req_data;
  logic [63:0]  bus_ad;
  logic [7:0]   bus_chk;
  logic         bus_valid, bus_addr_phase, bus_last;

  sysbus_wr_seq u_sysbus_wr_seq (
    .clk(clk), .rst_n(rst_n), .mode32(mode32), .gap_cfg(gap_cfg), .pipe_en(pipe_en),
    .wr_ready(wr_ready), .req_valid(req_valid), .req_ready(req_ready),
    .req_block(req_block), .req_size(req_size), .req_addr(req_addr), .req_data(req_data),
    .bus_ad(bus_ad), .bus_chk(bus_chk), .bus_cmd(bus_cmd), .bus_valid(bus_valid),
    .bus_addr_phase(bus_addr_phase), .bus_last(bus_last)
  );

  typedef struct packed {
    logic        v;
    logic        a;
    logic        l;
    logic [3:0]  cmd;
    logic [63:0] ad;
    logic [7:0]  chk;
    logic [7:0]  tag;
  } ent_t;

  ent_t q[$];
  int   checks = 0;
  int   errors = 0;
  bit   spare_m = 1'b0;
  bit   wr_v = 1'b0;
  bit   pipe_v = 1'b0;

  function automatic logic [7:0] par8(logic [63:0] d);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = ^d[8*i +: 8];
    return r;
  endfunction

  function automatic ent_t mk(bit v, bit a, bit l, logic [3:0] cmd, logic [63:0] ad, int tag);
    ent_t e;
    e.v = v; e.a = a; e.l = l; e.cmd = cmd; e.ad = ad; e.chk = par8(ad); e.tag = 8'(tag);
    return e;
  endfunction

  function automatic logic [255:0] pat(int k);
    logic [255:0] r;
    for (int i = 0; i < 8; i++) r[32*i +: 32] = (32'h1357_9bdf * 32'(k + i + 1)) ^ 32'(i << 24);
    return r;
  endfunction

  // Expected bus cycles of one request (R1..R6)
  task automatic push_xfer(bit blk, int size, logic [31:0] addr, logic [255:0] data, bit m32, int gap);
    bit split = !blk && m32 && size > 4;
    int halves = split ? 2 : 1;
    int nb = blk ? (m32 ? 8 : 4) : 1;
    for (int h = 0; h < halves; h++) begin
      logic [3:0] cmd;
      if (blk) cmd = 4'b1000;
      else cmd = {1'b0, 3'(split ? (h == 0 ? 3 : size - 5) : size - 1)};
      q.push_back(mk(1, 1, 0, cmd, {32'b0, addr + 32'(4 * h)}, 1));
      for (int g = 0; g < gap; g++) q.push_back(mk(0, 0, 0, 4'd0, 64'd0, 2));
      for (int b = 0; b < nb; b++) begin
        logic [63:0] w;
        int tag;
        if (m32) w = {32'b0, data[32*(blk ? b : h) +: 32]};
        else w = data[64*b +: 64];
        tag = blk ? (m32 ? 4 : 3) : ((split && h == 1) ? 6 : 5);
        q.push_back(mk(1, 0, b == nb - 1, 4'd0, w, tag));
      end
    end
  endtask

  task automatic cyc(bit v, bit blk, int size, logic [31:0] addr, logic [255:0] data,
                     bit m32, int gap, output bit acc);
    ent_t e;
    bit rdy_exp;
    @(negedge clk);
    req_valid = v; req_block = blk; req_size = 4'(size); req_addr = addr; req_data = data;
    mode32 = m32; gap_cfg = 3'(gap); wr_ready = wr_v; pipe_en = pipe_v;
    #1;
    e = (q.size() > 0) ? q[0] : mk(0, 0, 0, 4'd0, 64'd0, 11);
    checks++;
    if ({bus_valid, bus_addr_phase, bus_last, bus_cmd, bus_ad} !== {e.v, e.a, e.l, e.cmd, e.ad}) begin
      errors++;
      $display("FAIL R%0d bus v/a/l/cmd/ad actual=%b %b %b %h %h expected=%b %b %b %h %h",
               e.tag, bus_valid, bus_addr_phase, bus_last, bus_cmd, bus_ad,
               e.v, e.a, e.l, e.cmd, e.ad);
    end
    checks++;
    if (bus_chk !== e.chk) begin
      errors++;
      $display("FAIL R7 bus_chk actual=%h expected=%h", bus_chk, e.chk);
    end
    rdy_exp = (q.size() <= 1) && (wr_v || spare_m);
    checks++;
    if (req_ready !== rdy_exp) begin
      errors++;
      $display("FAIL R8/R9/R10 req_ready actual=%b expected=%b", req_ready, rdy_exp);
    end
    acc = v && req_ready;
    if (q.size() > 0) void'(q.pop_front());
    if (acc) push_xfer(blk, size, addr, data, m32, gap);
    spare_m = wr_v ? pipe_v : (acc ? 1'b0 : spare_m);
  endtask

  task automatic send(bit blk, int size, logic [31:0] addr, logic [255:0] data,
                      bit m32, int gap, int maxtry);
    bit got = 1'b0;
    for (int i = 0; i < maxtry && !got; i++) cyc(1, blk, size, addr, data, m32, gap, got);
  endtask

  task automatic idle(int n);
    bit got;
    for (int i = 0; i < n; i++) cyc(0, 0, 1, 32'd0, 256'd0, 0, 0, got);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_block = 1'b0; req_size = 4'd1; req_addr = '0;
    req_data = '0; mode32 = 1'b0; gap_cfg = '0; wr_ready = 1'b0; pipe_en = 1'b0;
    repeat (3) @(negedge clk);
    // R12: reset state
    checks++;
    if ({bus_valid, bus_addr_phase, bus_last, bus_cmd, bus_ad, bus_chk} !== '0) begin
      errors++;
      $display("FAIL R12 reset outputs actual=%b%b%b %h %h %h expected=0",
               bus_valid, bus_addr_phase, bus_last, bus_cmd, bus_ad, bus_chk);
    end
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    wr_v = 1'b1;
    idle(2);

    // R1 R5 R7: single writes on the wide bus
    send(0, 8, 32'h0000_1000, pat(1), 0, 0, 4);
    idle(3);
    send(0, 3, 32'h0000_2003, pat(2), 0, 0, 4);
    idle(2);
    // R8: back-to-back singles, one every 2 cycles
    send(0, 8, 32'h0000_3000, pat(3), 0, 0, 4);
    send(0, 4, 32'h0000_3008, pat(4), 0, 0, 4);
    send(0, 2, 32'h0000_3010, pat(5), 0, 0, 4);
    idle(3);
    // R2: programmable gap, including the maximum
    send(0, 8, 32'h0000_4000, pat(6), 0, 3, 4);
    idle(6);
    send(0, 1, 32'h0000_4100, pat(7), 0, 7, 4);
    idle(10);
    // R3: wide block
    send(1, 1, 32'h0000_5000, pat(8), 0, 2, 4);
    idle(8);
    // R4: narrow block
    send(1, 1, 32'h0000_5020, pat(9), 1, 0, 4);
    idle(10);
    // R6: narrow split single; R5 narrow small single
    send(0, 8, 32'h0000_6000, pat(10), 1, 1, 4);
    idle(8);
    send(0, 3, 32'h0000_6101, pat(11), 1, 0, 4);
    send(0, 5, 32'h0000_6200, pat(12), 1, 0, 4);
    idle(6);

    // R9 R10: no start without write-ready and no credit
    wr_v = 1'b0; pipe_v = 1'b0;
    send(0, 8, 32'h0000_7000, pat(13), 0, 0, 5);
    wr_v = 1'b1;
    send(0, 8, 32'h0000_7000, pat(13), 0, 0, 4);
    idle(3);

    // R10: one pipelined write after write-ready drops
    pipe_v = 1'b1;
    idle(1);
    wr_v = 1'b0;
    send(0, 8, 32'h0000_8000, pat(14), 0, 0, 3);
    send(0, 6, 32'h0000_8008, pat(15), 0, 1, 6);
    wr_v = 1'b1;
    send(0, 6, 32'h0000_8008, pat(15), 0, 1, 4);
    // credit held across a busy block, used at its last beat
    send(1, 1, 32'h0000_8100, pat(16), 0, 0, 4);
    wr_v = 1'b0;
    send(0, 2, 32'h0000_8200, pat(17), 0, 0, 8);
    send(0, 2, 32'h0000_8300, pat(18), 0, 0, 4);
    wr_v = 1'b1; pipe_v = 1'b0;
    idle(12);
    finish_run();
  end

endmodule